// File: doc/BRIEF.md
# NAND Page Column to Buffer RAM Segment Mapper

This block turns a byte column inside a NAND page, together with a transfer length, into a sequence of contiguous segments inside a flash controller's internal buffer RAM. The RAM holds the main data of a page as consecutive 512-byte buffers starting at address 0, so a main-area column maps to the same byte address. Spare bytes live in a separate bank of eight 64-byte buffers starting at 0x1000.

The page's spare bytes are divided among the 512-byte chunks of the page. Each chunk's buffer receives the same even-rounded share. Any bytes left over after that split are appended to the last chunk's buffer.

A request carries the column, the length and a spare-only flag. It is accepted on a valid/ready handshake. The block then presents one segment at a time on a valid/ready output. Each segment gives the buffer RAM address, the spare buffer index, the segment length, a main/spare flag, a last flag and an error flag.

The request input accepts only while no burst is in progress. The segment output may be stalled for any number of cycles. While it is stalled, every segment field stays unchanged. The burst advances by exactly one segment on each cycle in which seg_valid and seg_ready are both high. After the last segment there is one idle cycle before the next request can be accepted.

Top module: `nsm_addr_mapper`

## Requirements
- R1: After reset, seg_valid is 0 and req_ready is 1.
- R2: geom_sel selects the page/spare geometry: 0 gives 512/16, 1 gives 2048/64, 2 gives 4096/128 and 3 gives 4096/218. The per-buffer share is the spare size divided by (page size / 512), rounded down to an even number. This gives 16, 16, 16 and 26 bytes respectively.
- R3: When the column is below the page size and spare-only is 0, the first segment has seg_spare=0, seg_buf=0 and seg_addr equal to the column. Its seg_len is the smaller of the requested length and (page size − column).
- R4: If a main segment does not exhaust the length, the next segment is a spare access starting at spare offset 0.
- R5: A column at or above the page size starts a spare access at spare offset (column − page size). With req_spare_only=1, the column itself is the spare offset. All spare segments have seg_spare=1.
- R6: For a spare offset below the spare size, the buffer index is offset / share, clamped at 7. seg_buf equals that index. seg_addr equals 0x1000 + index·0x40 + (offset − index·share).
- R7: A spare segment's length is the smaller of the remaining length and the bytes left in the current buffer. In the last buffer (index = page size/512 − 1), the bytes left run up to the spare size; for geometry 3, buffer 7 therefore holds offsets 182 to 217. Each following segment continues at the next spare offset.
- R8: seg_last is 1 exactly when the segment length equals the remaining length. A zero-length request yields one segment with seg_len=0 and seg_last=1.
- R9: If a spare segment would start at an offset at or above the spare size, it is an error segment. An error segment has seg_err=1, seg_spare=1, seg_addr=0, seg_buf=0, seg_len equal to the remaining length, and seg_last=1.
- R10: A request is accepted when req_valid and req_ready are both high, and req_ready stays 0 until the last segment is taken. Segments advance only on seg_valid and seg_ready. All segment fields hold while seg_valid is high and seg_ready is low. After the last segment is taken, seg_valid is 0 in the next cycle.
- R11: The geometry is captured when a request is accepted. Changing geom_sel during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| geom_sel | input | 2 | Page/spare geometry code, captured at request acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (block idle) |
| req_col | input | 13 | Starting column (byte offset) |
| req_len | input | 13 | Transfer length in bytes |
| req_spare_only | input | 1 | Treat the column as a spare offset |
| seg_valid | output | 1 | Segment valid |
| seg_ready | input | 1 | Segment taken by consumer |
| seg_addr | output | 13 | Buffer RAM byte address of the segment start |
| seg_buf | output | 3 | Spare buffer index (0 for main or error segments) |
| seg_len | output | 13 | Bytes in this contiguous segment |
| seg_spare | output | 1 | 1 for a spare segment, 0 for a main segment |
| seg_last | output | 1 | Final segment of the request |
| seg_err | output | 1 | Spare offset ran past the spare size |

## Verification
The bench builds the block with its defaults: eight spare buffers of 0x40 bytes at 0x1000 and a 13-bit address. With these values, every geometry fits the address space. All four geometries can be reached, including the uneven 26-byte share with its 36-byte last buffer. Random columns and lengths are chosen so that they regularly cross from main to spare, walk through several spare buffers and run past the spare size into the error segment. Random back-pressure on seg_ready exercises the stall behaviour.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  localparam int OFS_W       = 13;
  localparam int CHUNK_BYTES = 512;
  localparam int CHUNK_LG    = $clog2(CHUNK_BYTES);

  typedef enum logic [1:0] {
    GEO_512_16 = 2'd0,
    GEO_2K_64  = 2'd1,
    GEO_4K_128 = 2'd2,
    GEO_4K_218 = 2'd3
  } geo_e;

  typedef struct packed {
    logic [OFS_W-1:0] page;
    logic [OFS_W-1:0] spare;
    logic [OFS_W-1:0] last_chunk;
    logic [OFS_W-1:0] per_buf;
  } geo_t;
endpackage

// File: rtl/nsm_geom_decode.sv
module nsm_geom_decode
  import nsm_pkg::*;
(
  input  logic [1:0] geom_sel,
  output geo_t       cfg
);
  logic [OFS_W-1:0] pg, sp;
  int               lg;
  int               sh;

  always_comb begin
    unique case (geo_e'(geom_sel))
      GEO_512_16: begin pg = OFS_W'(512);  sp = OFS_W'(16);  end
      GEO_2K_64:  begin pg = OFS_W'(2048); sp = OFS_W'(64);  end
      GEO_4K_128: begin pg = OFS_W'(4096); sp = OFS_W'(128); end
      GEO_4K_218: begin pg = OFS_W'(4096); sp = OFS_W'(218); end
    endcase
    // page sizes are powers of two: find log2, then chunk-count shift
    lg = 0;
    for (int i = 0; i < OFS_W; i++) begin
      if (pg[i]) lg = i;
    end
    sh = lg - CHUNK_LG;
    cfg.page       = pg;
    cfg.spare      = sp;
    cfg.last_chunk = (OFS_W'(1) << sh) - OFS_W'(1);
    cfg.per_buf    = (sp >> sh) & ~OFS_W'(1);
  end
endmodule

// File: rtl/nsm_spare_locate.sv
module nsm_spare_locate
  import nsm_pkg::*;
#(
  parameter int NUM_SPARE = 8
) (
  input  logic [OFS_W-1:0]             off,
  input  logic [OFS_W-1:0]             per_buf,
  input  logic [OFS_W-1:0]             spare,
  input  logic [OFS_W-1:0]             last_chunk,
  output logic [$clog2(NUM_SPARE)-1:0] idx,
  output logic [OFS_W-1:0]             in_off,
  output logic [OFS_W-1:0]             room
);
  localparam int IDX_W = $clog2(NUM_SPARE);

  logic [NUM_SPARE-1:1] past;
  logic [OFS_W-1:0]     base;

  // One threshold comparator per buffer boundary; the count of boundaries
  // passed is the index, which saturates at NUM_SPARE-1 by construction.
  for (genvar k = 1; k < NUM_SPARE; k++) begin : g_thr
    logic [OFS_W-1:0] thr;
    assign thr     = OFS_W'(k) * per_buf;
    assign past[k] = (off >= thr);
  end

  always_comb begin
    idx = '0;
    for (int k = 1; k < NUM_SPARE; k++) begin
      idx = idx + IDX_W'(past[k]);
    end
    base   = OFS_W'(idx) * per_buf;
    in_off = off - base;
    // the last used buffer also carries the odd leftover bytes
    room   = (OFS_W'(idx) == last_chunk) ? (spare - off) : (base + per_buf - off);
  end
endmodule

// File: rtl/nsm_seg_calc.sv
module nsm_seg_calc
  import nsm_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int NUM_SPARE    = 8,
  parameter int SPARE_BASE   = 'h1000,
  parameter int SPARE_STRIDE = 'h40
) (
  input  geo_t                         cfg,
  input  logic                         in_spare,
  input  logic [OFS_W-1:0]             off,
  input  logic [OFS_W-1:0]             rem,
  output logic [ADDR_W-1:0]            addr,
  output logic [$clog2(NUM_SPARE)-1:0] buf_idx,
  output logic [OFS_W-1:0]             len,
  output logic                         is_last,
  output logic                         is_err
);
  localparam int IDX_W = $clog2(NUM_SPARE);

  logic [IDX_W-1:0] sidx;
  logic [OFS_W-1:0] soff;
  logic [OFS_W-1:0] sroom;
  logic [OFS_W-1:0] cap;

  nsm_spare_locate #(.NUM_SPARE(NUM_SPARE)) loc_i (
    .off        (off),
    .per_buf    (cfg.per_buf),
    .spare      (cfg.spare),
    .last_chunk (cfg.last_chunk),
    .idx        (sidx),
    .in_off     (soff),
    .room       (sroom)
  );

  always_comb begin
    is_err  = in_spare && (off >= cfg.spare);
    cap     = in_spare ? sroom : (cfg.page - off);
    len     = is_err ? rem : ((rem < cap) ? rem : cap);
    is_last = (len == rem);
    buf_idx = (in_spare && !is_err) ? sidx : '0;
    if (is_err) begin
      addr = '0;
    end else if (in_spare) begin
      addr = ADDR_W'(SPARE_BASE) + ADDR_W'(sidx) * ADDR_W'(SPARE_STRIDE) + ADDR_W'(soff);
    end else begin
      addr = ADDR_W'(off);
    end
  end
endmodule

// File: rtl/nsm_addr_mapper.sv
module nsm_addr_mapper
  import nsm_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int NUM_SPARE    = 8,
  parameter int SPARE_BASE   = 'h1000,
  parameter int SPARE_STRIDE = 'h40,
  localparam int IDX_W       = $clog2(NUM_SPARE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        geom_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFS_W-1:0]  req_col,
  input  logic [OFS_W-1:0]  req_len,
  input  logic              req_spare_only,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [IDX_W-1:0]  seg_buf,
  output logic [OFS_W-1:0]  seg_len,
  output logic              seg_spare,
  output logic              seg_last,
  output logic              seg_err
);
  geo_t             cfg_new, cfg_q;
  logic             busy_q, in_spare_q;
  logic [OFS_W-1:0] off_q, rem_q;
  logic             start_spare;
  logic [OFS_W-1:0] start_off;
  logic             take;

  nsm_geom_decode geo_i (
    .geom_sel (geom_sel),
    .cfg      (cfg_new)
  );

  nsm_seg_calc #(
    .ADDR_W       (ADDR_W),
    .NUM_SPARE    (NUM_SPARE),
    .SPARE_BASE   (SPARE_BASE),
    .SPARE_STRIDE (SPARE_STRIDE)
  ) calc_i (
    .cfg      (cfg_q),
    .in_spare (in_spare_q),
    .off      (off_q),
    .rem      (rem_q),
    .addr     (seg_addr),
    .buf_idx  (seg_buf),
    .len      (seg_len),
    .is_last  (seg_last),
    .is_err   (seg_err)
  );

  assign req_ready = !busy_q;
  assign seg_valid = busy_q;
  assign seg_spare = in_spare_q;
  assign take      = seg_valid && seg_ready;

  // entry point of the walk: spare-only, past the page, or main
  always_comb begin
    if (req_spare_only) begin
      start_spare = 1'b1;
      start_off   = req_col;
    end else if (req_col >= cfg_new.page) begin
      start_spare = 1'b1;
      start_off   = req_col - cfg_new.page;
    end else begin
      start_spare = 1'b0;
      start_off   = req_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cfg_q      <= '0;
      in_spare_q <= 1'b0;
      off_q      <= '0;
      rem_q      <= '0;
    end else if (!busy_q) begin
      if (req_valid) begin
        busy_q     <= 1'b1;
        cfg_q      <= cfg_new;
        in_spare_q <= start_spare;
        off_q      <= start_off;
        rem_q      <= req_len;
      end
    end else if (take) begin
      if (seg_last) begin
        busy_q <= 1'b0;
      end else begin
        rem_q <= rem_q - seg_len;
        if (!in_spare_q) begin
          in_spare_q <= 1'b1;
          off_q      <= '0;
        end else begin
          off_q <= off_q + seg_len;
        end
      end
    end
  end

  // R10: a stalled segment keeps every field
  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len)
      && $stable(seg_last) && $stable(seg_err) && $stable(seg_buf));

  // R10: the burst ends one cycle after its last segment is taken
  assert_idle_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_ready && seg_last |=> !seg_valid);

  // R3: a main segment never crosses into the spare area
  assert_main_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_spare |-> int'(seg_addr) + int'(seg_len) <= int'(cfg_q.page));

  // R7: a spare segment stays inside its buffer
  assert_spare_in_buffer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_spare && !seg_err |->
      int'(seg_addr) - SPARE_BASE - int'(seg_buf) * SPARE_STRIDE + int'(seg_len) <= SPARE_STRIDE);

  // R6: only buffers backing real chunks are used
  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_spare && !seg_err |-> OFS_W'(seg_buf) <= cfg_q.last_chunk);

  // R8: every non-final segment moves the walk forward
  assert_progress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_last |-> seg_len != '0);

  // R11: geometry is frozen for the whole burst
  assert_geo_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !(seg_ready && seg_last) |=> $stable(cfg_q));
endmodule

// File: tb/nsm_addr_mapper_tb_top.sv
module nsm_addr_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  geom_sel = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [12:0] req_col = '0;
  logic [12:0] req_len = '0;
  logic        req_spare_only = 1'b0;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [12:0] seg_addr;
  logic [2:0]  seg_buf;
  logic [12:0] seg_len;
  logic        seg_spare, seg_last, seg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int e_n;
  int e_addr[16];
  int e_buf[16];
  int e_len[16];
  int e_sp[16];
  int e_last[16];
  int e_err[16];

  always #5 clk = ~clk;

  nsm_addr_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .geom_sel(geom_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_col(req_col),
    .req_len(req_len), .req_spare_only(req_spare_only),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_buf(seg_buf), .seg_len(seg_len), .seg_spare(seg_spare),
    .seg_last(seg_last), .seg_err(seg_err)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic add_seg(int a, int b, int l, int sp, int last, int err);
    e_addr[e_n] = a; e_buf[e_n] = b; e_len[e_n] = l;
    e_sp[e_n] = sp; e_last[e_n] = last; e_err[e_n] = err;
    e_n++;
  endtask

  // reference walk written straight from the requirements
  task automatic build_expect(int g, int col, int len, bit so);
    int pg, sp, ch, sb, off, rem, l, s, o, room;
    bit ins;
    pg = (g == 0) ? 512 : ((g == 1) ? 2048 : 4096);
    sp = (g == 0) ? 16 : ((g == 1) ? 64 : ((g == 2) ? 128 : 218));
    ch = pg / 512;
    sb = ((sp / ch) / 2) * 2;
    if (so) begin ins = 1; off = col; end
    else if (col >= pg) begin ins = 1; off = col - pg; end
    else begin ins = 0; off = col; end
    rem = len;
    e_n = 0;
    while (1) begin
      if (ins && off >= sp) begin
        add_seg(0, 0, rem, 1, 1, 1);
        break;
      end
      if (!ins) begin
        room = pg - off;
        l = (rem < room) ? rem : room;
        add_seg(off, 0, l, 0, (l == rem) ? 1 : 0, 0);
      end else begin
        s = off / sb;
        if (s > 7) s = 7;
        o = off - s * sb;
        room = (s == ch - 1) ? (sp - off) : (sb - o);
        l = (rem < room) ? rem : room;
        add_seg(4096 + s * 64 + o, s, l, 1, (l == rem) ? 1 : 0, 0);
      end
      if (l == rem) break;
      rem = rem - l;
      if (!ins) begin ins = 1; off = 0; end
      else off = off + l;
    end
  endtask

  task automatic run_req(int g, int col, int len, bit so, bit flip, string tag);
    int i;
    bit rdy;
    build_expect(g, col, len, so);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    geom_sel = 2'(g); req_col = 13'(col); req_len = 13'(len);
    req_spare_only = so; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) geom_sel = ~(2'(g));
    i = 0;
    while (i < e_n) begin
      if (!seg_valid) begin
        chk($sformatf("%s R10 seg_valid during burst", tag), 0, 1);
        seg_ready = 1'b0;
        return;
      end
      chk($sformatf("%s R10 req_ready busy", tag), int'(req_ready), 0);
      if (e_err[i] != 0) chk($sformatf("%s R9 addr", tag), int'(seg_addr), e_addr[i]);
      else if (e_sp[i] != 0) chk($sformatf("%s R6 addr", tag), int'(seg_addr), e_addr[i]);
      else chk($sformatf("%s R3 addr", tag), int'(seg_addr), e_addr[i]);
      chk($sformatf("%s R6 buf", tag), int'(seg_buf), e_buf[i]);
      chk($sformatf("%s R7 len", tag), int'(seg_len), e_len[i]);
      chk($sformatf("%s R5 spare", tag), int'(seg_spare), e_sp[i]);
      chk($sformatf("%s R8 last", tag), int'(seg_last), e_last[i]);
      chk($sformatf("%s R9 err", tag), int'(seg_err), e_err[i]);
      rdy = ($urandom % 4) != 0;
      seg_ready = rdy;
      @(negedge clk);
      if (rdy) i++;
    end
    seg_ready = 1'b0;
    chk($sformatf("%s R10 idle valid", tag), int'(seg_valid), 0);
    chk($sformatf("%s R10 idle ready", tag), int'(req_ready), 1);
  endtask

  initial begin
    int g, col, len, pg, sp;
    bit so;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 seg_valid", int'(seg_valid), 0);

    // directed corners
    run_req(3, 4096 + 182, 36, 0, 0, "R7 last-buffer-full");   // 0x11C0, len 36
    run_req(3, 4096 + 200, 10, 0, 0, "R7 last-buffer-tail");   // 0x11D2, len 10
    run_req(3, 4096 + 170, 40, 0, 0, "R7 into-last");
    run_req(0, 500, 40, 0, 0, "R4 main-to-spare-to-err");
    run_req(1, 0, 0, 0, 0, "R8 zero-length");
    run_req(2, 20, 30, 1, 0, "R5 spare-only-walk");
    run_req(3, 218, 5, 1, 0, "R9 spare-only-past-end");
    run_req(1, 2040, 30, 0, 1, "R11 geom-change");
    run_req(0, 0, 600, 0, 1, "R11 geom-change-small");
    run_req(2, 0, 4096 + 128, 0, 0, "R2 full-page");
    run_req(3, 0, 4096 + 218, 0, 0, "R2 full-page-218");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      g = int'($urandom % 4);
      pg = (g == 0) ? 512 : ((g == 1) ? 2048 : 4096);
      sp = (g == 0) ? 16 : ((g == 1) ? 64 : ((g == 2) ? 128 : 218));
      so = ($urandom % 4) == 0;
      if (so) col = int'($urandom % (sp + 4));
      else if (($urandom % 2) == 0) col = pg - int'($urandom % 40);
      else col = int'($urandom % (pg + sp + 4));
      if (($urandom % 3) == 0) len = int'($urandom % 17);
      else len = int'($urandom % (sp + 80));
      if (($urandom % 8) == 0) len = int'($urandom % (pg + sp + 50));
      run_req(g, col, len, so, ($urandom % 5) == 0, "R6 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule